// File: doc/BRIEF.md
# I2C Bus Recovery Engine

This block takes over the SCL and SDA lines of an I2C bus as open-drain drivers to clear a bus that a target has left hung. The usual cause is a reset that lands in the middle of a read, which leaves the target holding SDA low. A trigger can be conditional or forced. A conditional trigger acts only when the synchronised lines show a wedge, meaning either line is low. A forced trigger always runs the recovery sequence. When the block finishes, it releases both lines and returns the bus to the normal master engine.

A run first releases SCL and checks that it actually goes high. This check tolerates a target that stretches the clock for a short time. The block then waits one half-cycle and clocks the bus with SDA released. It stops clocking as soon as SDA reads high at the end of a low phase, and never sends more than a fixed number of pulses. It then issues a STOP condition. Two flags report the outcome: one says SCL could never be released, the other says SDA stayed low after the STOP. All timing is counted in half-cycles of a parameterised length. At a 100 MHz clock, the default of 500 cycles gives 5 us half-cycles, which is roughly 100 kHz clocking.

Top module: `i2c_unwedge`

## Requirements
- R1: A conditional trigger (`start_i`) while both synchronised lines read high causes no line activity, raises no flag and pulses `done_o` within two cycles.
- R2: A forced trigger (`force_i`), or a conditional trigger while either line reads low, starts a recovery run that drives the lines.
- R3: To release SCL, the block floats it, waits the synchroniser settle time and samples it. It makes up to TRY_MAX attempts, one half-cycle apart. If SCL is still low after the last attempt, the run aborts with `fail_scl_o` set and SCL is never driven low.
- R4: Each clock pulse drives SCL low for exactly HALF_CYC cycles with SDA released, and follows a half-cycle of SCL high.
- R5: The block sends at least one and at most PULSE_MAX pulses. The pulse whose low phase ends with SDA reading high is the last one.
- R6: The STOP is sent as follows: SDA is driven low while SCL is still low, SCL is released (with the R3 check) for a half-cycle, and then SDA is released. A run therefore contains exactly one STOP condition and no START condition.
- R7: If SDA reads low after it is released in the STOP, `fail_sda_o` is set.
- R8: Each run ends with a single-cycle `done_o`, after which `busy_o` is low and both enables are off. The fail flags hold their value until the next accepted trigger clears them. After reset, all outputs are low.
- R9: A trigger that arrives while `busy_o` is high is ignored, including during the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conditional trigger: runs only if a line reads low |
| force_i | input | 1 | Forced trigger: always runs |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_oe_o | output | 1 | 1 = pull SCL low |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| busy_o | output | 1 | Engine owns the bus |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_scl_o | output | 1 | SCL could not be released |
| fail_sda_o | output | 1 | SDA low after the STOP |

## Verification
Two pairs of events can land in the same cycle. The first is the end of a run and a new trigger: the bench raises `force_i` exactly in the `done_o` cycle and then expects `busy_o` to be low with no second run. The second is the early SDA exit and the pulse limit: a target model that releases SDA after exactly PULSE_MAX falling SCL edges forces both exit conditions to coincide. The bench then expects PULSE_MAX pulses, a clean STOP and no data flag. A model that releases SDA one edge later must instead produce the data flag and no STOP.

// File: rtl/i2c_unwedge_pkg.sv
package i2c_unwedge_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHK,     // SCL floated, settle then sample
    ST_GAP,     // half-cycle between release attempts
    ST_PRE,     // half-cycle before clocking
    ST_HIGH,    // SCL high half-cycle
    ST_LOW,     // SCL driven low half-cycle
    ST_STOP_A,  // SDA low while SCL low
    ST_STOP_B,  // SCL high, SDA low
    ST_STOP_C,  // SDA released, settle then sample
    ST_STOP_D,  // final half-cycle
    ST_FIN      // done cycle
  } uw_state_e;

  typedef enum logic [1:0] {
    RET_PRE,
    RET_HIGH,
    RET_STOP
  } uw_ret_e;

endpackage

// File: rtl/i2c_unwedge_sync.sv
module i2c_unwedge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES == 1) begin : g_one
      logic [WIDTH-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= d_i;
      end
      assign q_o = s_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_unwedge_timer.sv
module i2c_unwedge_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] value_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = value_i - TW'(1);
    else        cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/i2c_unwedge_ctrl.sv
module i2c_unwedge_ctrl
  import i2c_unwedge_pkg::*;
#(
  parameter int HALF_CYC  = 500,
  parameter int SETTLE    = 3,
  parameter int TRY_MAX   = 3,
  parameter int PULSE_MAX = 9,
  parameter int TW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          force_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_scl_o,
  output logic          fail_sda_o
);

  localparam int RW = $clog2(TRY_MAX + 1);
  localparam int PW = $clog2(PULSE_MAX + 1);
  localparam logic [TW-1:0] T_HALF   = TW'(HALF_CYC);
  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE);

  uw_state_e       state_q, state_d;
  uw_ret_e         ret_q, ret_d;
  logic [RW-1:0]   tries_q, tries_d;
  logic [PW-1:0]   pulses_q, pulses_d;
  logic            fscl_q, fscl_d;
  logic            fsda_q, fsda_d;
  logic            scl_oe_q, scl_oe_d;
  logic            sda_oe_q, sda_oe_d;

  // next-state process
  always_comb begin
    state_d    = state_q;
    ret_d      = ret_q;
    tries_d    = tries_q;
    pulses_d   = pulses_q;
    fscl_d     = fscl_q;
    fsda_d     = fsda_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = T_HALF;

    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          fscl_d = 1'b0;
          fsda_d = 1'b0;
          if (!force_i && scl_s_i && sda_s_i) begin
            state_d = ST_FIN;
          end else begin
            tries_d    = '0;
            pulses_d   = '0;
            ret_d      = RET_PRE;
            state_d    = ST_CHK;
            tmr_load_o = 1'b1;
            tmr_val_o  = T_SETTLE;
          end
        end
      end
      ST_CHK: begin
        if (tmr_zero_i) begin
          if (scl_s_i) begin
            tries_d    = '0;
            tmr_load_o = 1'b1;
            tmr_val_o  = T_HALF;
            unique case (ret_q)
              RET_PRE:  state_d = ST_PRE;
              RET_HIGH: state_d = ST_HIGH;
              default:  state_d = ST_STOP_B;
            endcase
          end else if (tries_q == RW'(TRY_MAX - 1)) begin
            fscl_d  = 1'b1;
            state_d = ST_FIN;
          end else begin
            tries_d    = tries_q + RW'(1);
            state_d    = ST_GAP;
            tmr_load_o = 1'b1;
            tmr_val_o  = T_HALF;
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero_i) begin
          state_d    = ST_CHK;
          tmr_load_o = 1'b1;
          tmr_val_o  = T_SETTLE;
        end
      end
      ST_PRE: begin
        if (tmr_zero_i) begin
          ret_d      = RET_HIGH;
          state_d    = ST_CHK;
          tmr_load_o = 1'b1;
          tmr_val_o  = T_SETTLE;
        end
      end
      ST_HIGH: begin
        if (tmr_zero_i) begin
          pulses_d   = pulses_q + PW'(1);
          state_d    = ST_LOW;
          tmr_load_o = 1'b1;
          tmr_val_o  = T_HALF;
        end
      end
      ST_LOW: begin
        if (tmr_zero_i) begin
          tmr_load_o = 1'b1;
          if (sda_s_i || (pulses_q == PW'(PULSE_MAX))) begin
            state_d   = ST_STOP_A;
            tmr_val_o = T_HALF;
          end else begin
            ret_d     = RET_HIGH;
            state_d   = ST_CHK;
            tmr_val_o = T_SETTLE;
          end
        end
      end
      ST_STOP_A: begin
        if (tmr_zero_i) begin
          ret_d      = RET_STOP;
          state_d    = ST_CHK;
          tmr_load_o = 1'b1;
          tmr_val_o  = T_SETTLE;
        end
      end
      ST_STOP_B: begin
        if (tmr_zero_i) begin
          state_d    = ST_STOP_C;
          tmr_load_o = 1'b1;
          tmr_val_o  = T_SETTLE;
        end
      end
      ST_STOP_C: begin
        if (tmr_zero_i) begin
          if (!sda_s_i) fsda_d = 1'b1;
          state_d    = ST_STOP_D;
          tmr_load_o = 1'b1;
          tmr_val_o  = T_HALF;
        end
      end
      ST_STOP_D: begin
        if (tmr_zero_i) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // line enables decoded from the next state so the outputs are glitch-free flops
  always_comb begin
    scl_oe_d = (state_d == ST_LOW) || (state_d == ST_STOP_A);
    sda_oe_d = (state_d == ST_STOP_A) || (state_d == ST_STOP_B) ||
               (((state_d == ST_CHK) || (state_d == ST_GAP)) && (ret_d == RET_STOP));
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ret_q    <= RET_PRE;
      tries_q  <= '0;
      pulses_q <= '0;
      fscl_q   <= 1'b0;
      fsda_q   <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      ret_q    <= ret_d;
      tries_q  <= tries_d;
      pulses_q <= pulses_d;
      fscl_q   <= fscl_d;
      fsda_q   <= fsda_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
    end
  end

  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign fail_scl_o = fscl_q;
  assign fail_sda_o = fsda_q;

endmodule

// File: rtl/i2c_unwedge.sv
module i2c_unwedge #(
  parameter int HALF_CYC    = 500,
  parameter int SYNC_STAGES = 2,
  parameter int TRY_MAX     = 3,
  parameter int PULSE_MAX   = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic force_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_scl_o,
  output logic fail_sda_o
);

  localparam int SETTLE  = SYNC_STAGES + 1;
  localparam int TMR_MAX = (HALF_CYC > SETTLE) ? HALF_CYC : SETTLE;
  localparam int TW      = $clog2(TMR_MAX + 1);

  logic [1:0]    line_s;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  i2c_unwedge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  i2c_unwedge_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (tmr_load),
    .value_i (tmr_val),
    .zero_o  (tmr_zero)
  );

  i2c_unwedge_ctrl #(
    .HALF_CYC  (HALF_CYC),
    .SETTLE    (SETTLE),
    .TRY_MAX   (TRY_MAX),
    .PULSE_MAX (PULSE_MAX),
    .TW        (TW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (start_i | force_i),
    .force_i    (force_i),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_scl_o (fail_scl_o),
    .fail_sda_o (fail_sda_o)
  );

endmodule

// File: rtl/i2c_unwedge_chk.sv
module i2c_unwedge_chk #(
  parameter int PULSE_MAX = 9
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic force_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_scl_o,
  input logic fail_sda_o
);

  localparam int CW = $clog2(PULSE_MAX + 2);

  logic [CW-1:0] pulse_cnt_q;
  logic          scl_oe_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt_q   <= '0;
      scl_oe_prev_q <= 1'b0;
    end else begin
      scl_oe_prev_q <= scl_oe_o;
      if (!busy_o)
        pulse_cnt_q <= '0;
      else if (scl_oe_o && !scl_oe_prev_q && (pulse_cnt_q != '1))
        pulse_cnt_q <= pulse_cnt_q + CW'(1);
    end
  end

  p_pulse_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt_q <= CW'(PULSE_MAX));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_released_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !force_i) |=> $stable({fail_scl_o, fail_sda_o}));

  p_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> scl_oe_o);

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_scl_o && fail_sda_o));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

endmodule

bind i2c_unwedge i2c_unwedge_chk #(.PULSE_MAX(PULSE_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .force_i    (force_i),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_scl_o (fail_scl_o),
  .fail_sda_o (fail_sda_o)
);

// File: tb/i2c_unwedge_tb_top.sv
module i2c_unwedge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;
  localparam int PMAX       = 9;

  logic clk;
  logic rst_n;
  logic start_in, frc_in;
  logic scl_oe, sda_oe, busy, done, fail_scl, fail_sda;
  logic scl_bus, sda_bus;

  // target model
  logic scl_stuck;
  int   stretch_left;
  logic tgt_sda_active;
  int   tgt_k;
  int   fall_cnt;

  int checks, failures;

  // monitor
  logic mon_en;
  int   m_pulses, m_low_bad, m_stops, m_starts, m_done;
  int   low_len;
  logic low_has_sda, prev_oe, prev_scl, prev_sda;

  assign scl_bus = !scl_oe && !scl_stuck && (stretch_left == 0);
  assign sda_bus = !sda_oe && !tgt_sda_active;

  i2c_unwedge #(.HALF_CYC(HALF), .SYNC_STAGES(2), .TRY_MAX(3), .PULSE_MAX(PMAX)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_in),
    .force_i    (frc_in),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .busy_o     (busy),
    .done_o     (done),
    .fail_scl_o (fail_scl),
    .fail_sda_o (fail_sda)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (stretch_left > 0) stretch_left <= stretch_left - 1;

  // target lets SDA go after tgt_k falling SCL edges
  always @(negedge scl_bus) begin
    if (tgt_sda_active) begin
      fall_cnt = fall_cnt + 1;
      if (fall_cnt >= tgt_k) tgt_sda_active = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (scl_oe && !prev_oe) begin
        m_pulses++;
        low_len     = 0;
        low_has_sda = 1'b0;
      end
      if (scl_oe) begin
        low_len++;
        if (sda_oe) low_has_sda = 1'b1;
      end
      if (!scl_oe && prev_oe && !low_has_sda && low_len != HALF) m_low_bad++;
      if (scl_bus && prev_scl && sda_bus && !prev_sda) m_stops++;
      if (scl_bus && prev_scl && !sda_bus && prev_sda) m_starts++;
      if (done) m_done++;
    end
    prev_oe  = scl_oe;
    prev_scl = scl_bus;
    prev_sda = sda_bus;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_pulses(input bit quick, input bit stuck, input int k);
    if (quick || stuck) return 0;
    if (k == 0) return 1;
    return (k < PMAX) ? k : PMAX;
  endfunction

  task automatic run(input bit use_force, input int k, input int stretch, input bit stuck,
                     input int retrig_at, input bit retrig_on_done);
    bit quick;
    int cyc;
    bit e_fscl, e_fsda;
    int e_stops;
    m_pulses = 0; m_low_bad = 0; m_stops = 0; m_starts = 0; m_done = 0;
    low_len = 0; low_has_sda = 1'b0;
    @(negedge clk);
    scl_stuck    = stuck;
    stretch_left = stretch;
    @(negedge clk);
    fall_cnt       = 0;
    tgt_k          = k;
    tgt_sda_active = (k > 0);
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    if (use_force) frc_in = 1'b1; else start_in = 1'b1;
    @(negedge clk);
    frc_in = 1'b0; start_in = 1'b0;
    cyc = 1;
    while (m_done == 0 && cyc < 5000) begin
      if (retrig_at > 0 && cyc == retrig_at) frc_in = 1'b1;
      @(negedge clk);
      frc_in = 1'b0;
      cyc++;
    end
    quick = !use_force && k == 0 && stretch == 0 && !stuck;
    chk("R8", "run finished", int'(m_done > 0), 1);
    if (quick) chk("R1", "done latency ok", int'(cyc <= 2), 1);
    if (retrig_on_done && done) begin
      frc_in = 1'b1;
      @(negedge clk);
      frc_in = 1'b0;
      chk("R9", "busy after trigger in done cycle", int'(busy), 0);
    end
    repeat (5) @(negedge clk);
    mon_en = 1'b0;
    e_fscl  = stuck;
    e_fsda  = !quick && !stuck && k > PMAX;
    e_stops = (!quick && !stuck && k <= PMAX) ? 1 : 0;
    chk("R8", "done count", m_done, 1);
    chk("R8", "busy after run", int'(busy), 0);
    chk("R5", "pulse count", m_pulses, exp_pulses(quick, stuck, k));
    chk("R4", "low phase width errors", m_low_bad, 0);
    chk("R3", "fail_scl", int'(fail_scl), int'(e_fscl));
    chk("R7", "fail_sda", int'(fail_sda), int'(e_fsda));
    chk("R6", "stop count", m_stops, e_stops);
    chk("R6", "start count", m_starts, 0);
    if (!quick && !stuck) chk("R2", "run drove lines", int'(m_pulses > 0), 1);
    tgt_sda_active = 1'b0;
    scl_stuck      = 1'b0;
    stretch_left   = 0;
    repeat (6) @(negedge clk);
    chk("R8", "flags held after run", int'({fail_scl, fail_sda}), int'({e_fscl, e_fsda}));
  endtask

  initial begin
    checks = 0; failures = 0;
    start_in = 1'b0; frc_in = 1'b0; scl_stuck = 1'b0; stretch_left = 0;
    tgt_sda_active = 1'b0; tgt_k = 0; fall_cnt = 0; mon_en = 1'b0;
    prev_oe = 1'b0; prev_scl = 1'b1; prev_sda = 1'b1;
    rst_n = 1'b0;
    void'($urandom(32'h5eed_1c2d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", "reset outputs", int'({scl_oe, sda_oe, busy, done, fail_scl, fail_sda}), 0);

    run(1'b0, 0, 0, 1'b0, 0, 1'b0);   // R1 healthy, conditional
    run(1'b1, 0, 0, 1'b0, 0, 1'b0);   // R2 forced on healthy bus: one pulse
    run(1'b0, 4, 0, 1'b0, 0, 1'b0);   // R2 conditional with SDA stuck
    run(1'b1, 0, 0, 1'b1, 0, 1'b0);   // R3 SCL stuck
    run(1'b1, 3, 25, 1'b0, 0, 1'b0);  // R3 short stretch tolerated
    run(1'b1, PMAX, 0, 1'b0, 0, 1'b0);     // R5 release on last allowed pulse
    run(1'b1, PMAX + 1, 0, 1'b0, 0, 1'b0); // R7 SDA never released
    run(1'b1, 5, 0, 1'b0, 60, 1'b0);  // R9 retrigger mid-run
    run(1'b1, 2, 0, 1'b0, 0, 1'b1);   // R9 retrigger in done cycle
    run(1'b0, 0, 0, 1'b0, 0, 1'b1);   // R9 quick path with retrigger in done cycle

    for (int i = 0; i < 24; i++) begin
      bit f;
      int k, s;
      f = 1'($urandom % 2);
      k = int'($urandom % 13);
      s = ((($urandom % 3) == 0) ? 12 : 0);
      run(f, k, s, 1'b0, 0, 1'($urandom % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule